// File: doc/BRIEF.md
# Two-Word Coprocessor Load/Store Sequencer

This block sits between a memory beat stream of 32-bit words and a file of 64-bit coprocessor registers. Each transfer carries an instruction word that selects the target register and whether one word or two words move. A load writes incoming beats into the register, and a store presents register contents one beat at a time on the read-data output. A small beat counter decides which half of the 64-bit register the current word belongs to. An endianness input sets the order of the halves for two-word transfers.

A control strobe starts or aborts a transfer. It clears the counter and reports completion. Each data beat returns one response in the same cycle: "increment the address and continue" or "done". Address generation belongs to the surrounding pipeline. For single-word transfers the data type matters. A floating-point word occupies the upper half of the register. A 32-bit integer lives in the lower half, and a load of one sign-extends it to the full 64 bits.

Top module: `cpls_seq`

## Requirements
- R1: After reset every register holds zero and the beat counter is zero, so a first data beat is accepted without a prior control strobe.
- R2: Instruction bit 22 set selects a two-word transfer and clear selects a single word. Instruction bits 15:12 give the register index. All other instruction bits have no effect.
- R3: A control strobe clears the beat counter and raises `resp_done` in the same cycle. A data beat presented in that cycle is ignored: it writes nothing and `rdata` stays zero.
- R4: In a two-word transfer the first accepted beat raises `resp_inc` only, and the second raises `resp_done` only.
- R5: When `big_endian` is 1, the first beat of a two-word transfer maps to the upper half (bits 63:32) and the second to the lower half (bits 31:0). When it is 0 the order is reversed. This applies to both loads and stores.
- R6: A single-word float load (`is_int`=0) writes only the upper half and leaves the lower half unchanged. A single-word float store returns the upper half.
- R7: A single-word integer load (`is_int`=1) writes the word to the lower half and copies its bit 31 into all 32 upper bits. A single-word integer store returns the lower half.
- R8: A data beat that arrives while the counter is 2 is ignored: no register changes, neither response rises, and `rdata` is zero.
- R9: A single-word beat raises `resp_done`. After it, and after the second beat of a two-word transfer, the counter holds at 2 until the next control strobe.
- R10: `rdata` is zero in every cycle without an accepted store beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_strobe | input | 1 | Start/abort: clears the beat counter |
| beat_valid | input | 1 | One memory data beat this cycle |
| instr | input | 32 | Instruction word (bit 22 = two-word, bits 15:12 = register index) |
| is_load | input | 1 | 1 = memory to register, 0 = register to memory |
| is_int | input | 1 | Single-word type: 1 = 32-bit integer, 0 = float |
| big_endian | input | 1 | Half order for two-word transfers |
| wdata | input | 32 | Load data beat |
| rdata | output | 32 | Store data beat (zero when idle) |
| resp_inc | output | 1 | Beat accepted, increment the address and continue |
| resp_done | output | 1 | Transfer complete |

## Verification
The assertions check the following every cycle: the two responses never rise together, a strobe always leaves the counter at zero, the counter never reaches 3, a beat that follows an increment completes the pair, idle cycles keep `rdata` at zero, and a cycle without a write leaves every register intact. Only the bench scenarios can show where data lands. That covers the half chosen under each endianness, sign extension of integer loads, float loads that preserve the lower half, correct index decoding with junk in the other instruction bits, and the read-back of values that ignored beats and aborted beats must not have changed.

// File: rtl/cpls_pkg.sv
package cpls_pkg;
  localparam int INSTR_W  = 32;
  localparam int WIDE_BIT = 22;
  localparam int IDX_LSB  = 12;
  localparam int IDX_FLD  = 4;
  localparam logic [1:0] CNT_FIRST = 2'd0;
  localparam logic [1:0] CNT_SECOND = 2'd1;
  localparam logic [1:0] CNT_SPENT = 2'd2;
endpackage

// File: rtl/cpls_beat_ctr.sv
module cpls_beat_ctr
  import cpls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       advance,
  input  logic       wide,
  output logic [1:0] cnt
);
  logic [1:0] cnt_d;
  logic       cnt_en;

  always_comb begin
    cnt_en = clear | advance;
    cnt_d  = cnt;
    if (clear)
      cnt_d = CNT_FIRST;
    else if (advance)
      cnt_d = wide ? cnt + 2'd1 : CNT_SPENT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= CNT_FIRST;
    else if (cnt_en)
      cnt <= cnt_d;
  end

  assert_ctr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == CNT_FIRST);
  assert_single_spent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wide && !clear) |=> cnt == CNT_SPENT);
endmodule

// File: rtl/cpls_lane_map.sv
module cpls_lane_map #(
  parameter int WORD_W = 32
) (
  input  logic                wide,
  input  logic                first,
  input  logic                big_endian,
  input  logic                is_int,
  input  logic                is_load,
  input  logic                accept,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [2*WORD_W-1:0] row,
  output logic                wr_hi_en,
  output logic                wr_lo_en,
  output logic [WORD_W-1:0]   wr_hi_data,
  output logic [WORD_W-1:0]   wr_lo_data,
  output logic [WORD_W-1:0]   rdata
);
  logic hi_sel;
  logic sext;

  always_comb begin
    if (wide)
      hi_sel = big_endian ? first : !first;
    else
      hi_sel = !is_int;
    sext = !wide && is_int;

    wr_hi_en   = accept && is_load && (hi_sel || sext);
    wr_lo_en   = accept && is_load && (!hi_sel);
    wr_lo_data = wdata;
    wr_hi_data = sext ? {WORD_W{wdata[WORD_W-1]}} : wdata;

    rdata = '0;
    if (accept && !is_load)
      rdata = hi_sel ? row[2*WORD_W-1:WORD_W] : row[WORD_W-1:0];
  end
endmodule

// File: rtl/cpls_regfile.sv
module cpls_regfile #(
  parameter int NUM_REGS = 16,
  parameter int WORD_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    idx,
  input  logic                wr_hi_en,
  input  logic                wr_lo_en,
  input  logic [WORD_W-1:0]   wr_hi_data,
  input  logic [WORD_W-1:0]   wr_lo_data,
  output logic [2*WORD_W-1:0] row
);
  logic [NUM_REGS-1:0][2*WORD_W-1:0] mem;
  logic [NUM_REGS-1:0][2*WORD_W-1:0] mem_d;
  logic [NUM_REGS-1:0]               row_en;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
    always_comb begin
      row_en[g] = (idx == IDX_W'(g)) && (wr_hi_en || wr_lo_en);
      mem_d[g]  = mem[g];
      if (wr_hi_en) mem_d[g][2*WORD_W-1:WORD_W] = wr_hi_data;
      if (wr_lo_en) mem_d[g][WORD_W-1:0]        = wr_lo_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (row_en[g])
        mem[g] <= mem_d[g];
    end
  end

  assign row = mem[idx];

  assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi_en && !wr_lo_en) |=> $stable(mem));
endmodule

// File: rtl/cpls_seq.sv
module cpls_seq
  import cpls_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int WORD_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_strobe,
  input  logic               beat_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               is_load,
  input  logic               is_int,
  input  logic               big_endian,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  output logic               resp_inc,
  output logic               resp_done
);
  logic [1:0]          cnt;
  logic                wide;
  logic                first;
  logic                accept;
  logic [IDX_W-1:0]    idx;
  logic                wr_hi_en;
  logic                wr_lo_en;
  logic [WORD_W-1:0]   wr_hi_data;
  logic [WORD_W-1:0]   wr_lo_data;
  logic [2*WORD_W-1:0] row;

  always_comb begin
    wide      = instr[WIDE_BIT];
    idx       = instr[IDX_LSB +: IDX_W];
    first     = (cnt == CNT_FIRST);
    accept    = beat_valid && !ctl_strobe && (cnt != CNT_SPENT);
    resp_inc  = accept && wide && first;
    resp_done = ctl_strobe || (accept && !(wide && first));
  end

  cpls_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctl_strobe),
    .advance (accept),
    .wide    (wide),
    .cnt     (cnt)
  );

  cpls_lane_map #(.WORD_W(WORD_W)) u_lane (
    .wide       (wide),
    .first      (first),
    .big_endian (big_endian),
    .is_int     (is_int),
    .is_load    (is_load),
    .accept     (accept),
    .wdata      (wdata),
    .row        (row),
    .wr_hi_en   (wr_hi_en),
    .wr_lo_en   (wr_lo_en),
    .wr_hi_data (wr_hi_data),
    .wr_lo_data (wr_lo_data),
    .rdata      (rdata)
  );

  cpls_regfile #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (idx),
    .wr_hi_en   (wr_hi_en),
    .wr_lo_en   (wr_lo_en),
    .wr_hi_data (wr_hi_data),
    .wr_lo_data (wr_lo_data),
    .row        (row)
  );

  assert_inc_done_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_inc && resp_done));
  assert_pair_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(resp_inc) && beat_valid && !ctl_strobe && wide) |-> (resp_done && !resp_inc));
  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid || is_load || ctl_strobe) |-> rdata == '0);
  assert_sext_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_en && wr_lo_en) |-> wr_hi_data == {WORD_W{wr_lo_data[WORD_W-1]}});
endmodule

// File: tb/test_cpls_seq.sv
module test_cpls_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_strobe, beat_valid, is_load, is_int, big_endian;
  logic [31:0] instr, wdata, rdata;
  logic        resp_inc, resp_done;
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 1'b0;
  logic [63:0] model [16];

  always #2 clk = ~clk;

  cpls_seq i_cpls_seq (
    .clk(clk), .rst_n(rst_n), .ctl_strobe(ctl_strobe), .beat_valid(beat_valid),
    .instr(instr), .is_load(is_load), .is_int(is_int), .big_endian(big_endian),
    .wdata(wdata), .rdata(rdata), .resp_inc(resp_inc), .resp_done(resp_done)
  );

  function automatic logic [31:0] mk_instr(bit wd, int idx);
    logic [31:0] v;
    v = 32'hA5F3_5A6C & ~(32'h1 << 22) & ~(32'hF << 12);
    return v | (32'(wd) << 22) | (32'(idx) << 12);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(bit ctl, bit bv, bit ld, bit it, bit wd, bit be, int idx,
                      logic [31:0] d, bit e_inc, bit e_done, logic [31:0] e_rd,
                      string tag);
    @(negedge clk);
    ctl_strobe = ctl; beat_valid = bv; is_load = ld; is_int = it;
    big_endian = be; instr = mk_instr(wd, idx); wdata = d;
    #1;
    check({tag, " inc"}, 32'(resp_inc), 32'(e_inc));
    check({tag, " done"}, 32'(resp_done), 32'(e_done));
    check({tag, " rdata"}, rdata, e_rd);
    @(posedge clk);
    @(negedge clk);
    ctl_strobe = 0; beat_valid = 0;
  endtask

  task automatic strobe();
    xfer(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R3 strobe");
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctl_strobe = 0; beat_valid = 0; is_load = 0; is_int = 0;
    big_endian = 0; instr = 0; wdata = 0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 check("R10 idle rdata after reset", rdata, 0);

    // R1: first beat accepted with no strobe, register reads zero
    xfer(0, 1, 0, 1, 0, 0, 3, 0, 0, 1, 32'h0, "R1 reset read");
    // R9/R8: counter now spent, next beat ignored
    xfer(0, 1, 1, 1, 0, 0, 3, 32'hDEAD_BEEF, 0, 0, 0, "R8 ignored after single");

    // R2 R4 R5: two-word sweep over endianness and all indices
    for (int be = 0; be < 2; be++) begin
      for (int idx = 0; idx < 16; idx++) begin
        logic [31:0] a, b;
        a = 32'h1357_0000 ^ (32'(idx) * 32'h0101_0101) ^ (32'(be) << 31);
        b = ~a ^ 32'h0F0F_00FF;
        strobe();
        xfer(0, 1, 1, 0, 1, be[0], idx, a, 1, 0, 0, "R4 load beat0");
        xfer(0, 1, 1, 0, 1, be[0], idx, b, 0, 1, 0, "R4 load beat1");
        model[idx] = be[0] ? {a, b} : {b, a};
        xfer(0, 1, 1, 0, 1, be[0], idx, 32'hFFFF_FFFF, 0, 0, 0, "R8 third beat");
        strobe();
        xfer(0, 1, 0, 0, 1, be[0], idx, 0, 1, 0,
             be[0] ? model[idx][63:32] : model[idx][31:0], "R5 store beat0");
        xfer(0, 1, 0, 0, 1, be[0], idx, 0, 0, 1,
             be[0] ? model[idx][31:0] : model[idx][63:32], "R5 store beat1");
      end
    end

    // R6 R7: single-word float and integer per index
    for (int idx = 0; idx < 16; idx++) begin
      logic [31:0] f, n;
      f = 32'h3F80_0000 + 32'(idx);
      n = (idx % 2 == 0) ? (32'h8000_0001 + 32'(idx)) : (32'h0000_7FF0 + 32'(idx));
      strobe();
      xfer(0, 1, 1, 0, 0, 0, idx, f, 0, 1, 0, "R6 float load");
      model[idx][63:32] = f;
      strobe();
      xfer(0, 1, 0, 1, 0, 1, idx, 0, 0, 1, model[idx][31:0], "R6 lower kept, R7 int store");
      strobe();
      xfer(0, 1, 0, 0, 0, 1, idx, 0, 0, 1, f, "R6 float store");
      strobe();
      xfer(0, 1, 1, 1, 0, 0, idx, n, 0, 1, 0, "R7 int load");
      model[idx] = {{32{n[31]}}, n};
      strobe();
      xfer(0, 1, 0, 0, 1, 0, idx, 0, 1, 0, model[idx][31:0], "R7 sext lo");
      xfer(0, 1, 0, 0, 1, 0, idx, 0, 0, 1, model[idx][63:32], "R7 sext hi");
    end

    // R3: beat in the same cycle as strobe is ignored
    xfer(1, 1, 1, 1, 0, 0, 5, 32'h1234_5678, 0, 1, 0, "R3 beat with strobe");
    xfer(1, 1, 0, 1, 0, 0, 5, 0, 0, 1, 0, "R3 store with strobe");
    xfer(0, 1, 0, 1, 0, 0, 5, 0, 0, 1, model[5][31:0], "R3 no write");
    // R3: abort mid-pair restarts at first half
    strobe();
    xfer(0, 1, 0, 0, 1, 1, 9, 0, 1, 0, model[9][63:32], "R3 pair start");
    strobe();
    xfer(0, 1, 0, 0, 1, 1, 9, 0, 1, 0, model[9][63:32], "R3 restart first half");
    // R10: load beats never drive rdata
    strobe();
    xfer(0, 1, 1, 0, 0, 0, 2, 32'hCAFE_F00D, 0, 1, 0, "R10 load rdata zero");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule